// File: doc/BRIEF.md
# Local-to-PCI Address Window Translator

This block sits between a CPU local bus and a PCI host interface. It holds three outbound address windows: two for memory and one for I/O. Each window has three registers: a base address, a range mask and a remap word. When a local-bus address falls inside an enabled window, the block returns the window number and the PCI address the access should use. It also returns a flag that sends the access either to the standard PCI segment or to the CardBus segment.

Software programs the windows through a write-only register port. Lookups are presented one per cycle. Each lookup is answered exactly one clock later with one of two results:
- a hit, giving the window index, the translated address and the CardBus flag;
- a decode error, when no window claims the address.

There is a single I/O window. It therefore serves only one segment at a time, and its CardBus bit chooses which one.

Top module: `l2p_window_xlate`

## Requirements
- R1: After reset every window is disabled. Every lookup then returns a decode error (xl_decerr=1, xl_hit=0).
- R2: The registers of window w (0, 1 = memory, 2 = I/O) are at byte offsets 0x120+12*w (range), 0x124+12*w (base) and 0x128+12*w (remap). A write to any other offset changes no lookup result.
- R3: The base, the range and the address field of the remap word keep only bits 31:15 of the written value, which gives 32 KB granularity. Bits 14:0 of a hit's translated address always equal bits 14:0 of the lookup address.
- R4: An enabled window hits when (addr & range) == (base & range). On a hit, xl_hit=1 and xl_decerr=0.
- R5: Bit 0 of the remap word enables the window. A window with this bit clear never hits, whatever its base and range hold.
- R6: The translated address is (remap_field & range) | (addr & ~range), where remap_field is the remap word with bits 14:0 cleared.
- R7: xl_cardbus equals bit 2 of the winning window's remap word. For the I/O window this bit alone decides the segment.
- R8: When several windows hit, the lowest-numbered one wins, and xl_win reports its index.
- R9: On a miss, xl_hit=0, xl_decerr=1, xl_win=0, xl_addr=0 and xl_cardbus=0.
- R10: xl_valid is lk_valid delayed by one clock. While xl_valid=0, the outputs xl_hit, xl_decerr, xl_win, xl_addr and xl_cardbus are all 0.
- R11: A register write takes effect for lookups in later cycles. A lookup in the same cycle as the write still sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Local-bus address to decode |
| xl_valid | output | 1 | Result valid, one clock after the request |
| xl_hit | output | 1 | Some enabled window claimed the address |
| xl_decerr | output | 1 | No window claimed the address |
| xl_win | output | 2 | Index of the winning window |
| xl_addr | output | 32 | Translated PCI address |
| xl_cardbus | output | 1 | Access targets the CardBus segment |

## Verification
A corrupted base, range or enable bit shows up at the first lookup that touches that window. Within one clock it appears as a wrong hit/decode-error pair, or as a wrong translated high address. Addresses just inside and just outside each window boundary catch a wrong mask. Overlapping windows catch a broken priority. Lookups issued in the same cycle as a write catch a setting that takes effect too early. A stale CardBus bit surfaces as a wrong segment flag on the very next I/O-window hit.

// File: rtl/l2p_xlate_pkg.sv
package l2p_xlate_pkg;

    localparam int XA_W = 32;
    localparam int GRAN_LSB = 15;
    localparam logic [XA_W-1:0] GRAN_MASK = 32'hFFFF_8000;
    localparam int EN_BIT = 0;
    localparam int CB_BIT = 2;

    typedef logic [XA_W-1:0] xaddr_t;

    // One window as held in storage; address fields already granular.
    typedef struct packed {
        xaddr_t range_m;
        xaddr_t base;
        xaddr_t remap;
        logic   en;
        logic   cb;
    } win_cfg_t;

    // Per-window decode outcome.
    typedef struct packed {
        logic   hit;
        logic   cb;
        xaddr_t addr;
    } match_t;

    function automatic logic win_claims(xaddr_t a, win_cfg_t c);
        return c.en && ((a & c.range_m) == (c.base & c.range_m));
    endfunction

    function automatic xaddr_t win_translate(xaddr_t a, win_cfg_t c);
        return (c.remap & c.range_m) | (a & ~c.range_m);
    endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
    import l2p_xlate_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int CFG_AW = 12,
    parameter int REG_BASE = 'h120,
    parameter int REG_STRIDE = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we_i,
    input  logic [CFG_AW-1:0]          addr_i,
    input  logic [XA_W-1:0]            wdata_i,
    output win_cfg_t [NUM_WIN-1:0]     cfg_o
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [CFG_AW-1:0] OFS_RNG = CFG_AW'(REG_BASE + REG_STRIDE * g);
        localparam logic [CFG_AW-1:0] OFS_BAS = CFG_AW'(REG_BASE + REG_STRIDE * g + 4);
        localparam logic [CFG_AW-1:0] OFS_RMP = CFG_AW'(REG_BASE + REG_STRIDE * g + 8);

        win_cfg_t r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we_i) begin
                if (addr_i == OFS_RNG) r.range_m <= wdata_i & GRAN_MASK;
                if (addr_i == OFS_BAS) r.base    <= wdata_i & GRAN_MASK;
                if (addr_i == OFS_RMP) begin
                    r.remap <= wdata_i & GRAN_MASK;
                    r.en    <= wdata_i[EN_BIT];
                    r.cb    <= wdata_i[CB_BIT];
                end
            end
        end

        assign cfg_o[g] = r;
    end

endmodule

// File: rtl/win_match.sv
module win_match
    import l2p_xlate_pkg::*;
(
    input  xaddr_t   addr_i,
    input  win_cfg_t cfg_i,
    output match_t   res_o
);

    always_comb begin
        res_o.hit  = win_claims(addr_i, cfg_i);
        res_o.cb   = cfg_i.cb;
        res_o.addr = win_translate(addr_i, cfg_i);
    end

endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import l2p_xlate_pkg::*;
#(
    parameter int NUM_WIN = 3,
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  match_t [NUM_WIN-1:0] m_i,
    output logic                 hit_o,
    output logic [WIN_IW-1:0]    idx_o,
    output xaddr_t               addr_o,
    output logic                 cb_o
);

    always_comb begin
        hit_o  = 1'b0;
        idx_o  = '0;
        addr_o = '0;
        cb_o   = 1'b0;
        // Walk from the highest index down so the lowest hitting one is kept.
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (m_i[i].hit) begin
                hit_o  = 1'b1;
                idx_o  = WIN_IW'(i);
                addr_o = m_i[i].addr;
                cb_o   = m_i[i].cb;
            end
        end
    end

endmodule

// File: rtl/l2p_window_xlate.sv
module l2p_window_xlate
    import l2p_xlate_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int CFG_AW = 12,
    parameter int REG_BASE = 'h120,
    parameter int REG_STRIDE = 12,
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [XA_W-1:0]    cfg_wdata,
    input  logic               lk_valid,
    input  logic [XA_W-1:0]    lk_addr,
    output logic               xl_valid,
    output logic               xl_hit,
    output logic               xl_decerr,
    output logic [WIN_IW-1:0]  xl_win,
    output logic [XA_W-1:0]    xl_addr,
    output logic               xl_cardbus
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    match_t   [NUM_WIN-1:0] mt;
    logic     [NUM_WIN-1:0] hit_vec;
    logic     [NUM_WIN-1:0] win_en;

    logic              sel_hit;
    logic [WIN_IW-1:0] sel_idx;
    xaddr_t            sel_addr;
    logic              sel_cb;

    win_regs #(
        .NUM_WIN   (NUM_WIN),
        .CFG_AW    (CFG_AW),
        .REG_BASE  (REG_BASE),
        .REG_STRIDE(REG_STRIDE)
    ) regs_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .wdata_i(cfg_wdata),
        .cfg_o  (cfg)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
        win_match match_i (
            .addr_i(lk_addr),
            .cfg_i (cfg[g]),
            .res_o (mt[g])
        );
        assign hit_vec[g] = mt[g].hit;
        assign win_en[g]  = cfg[g].en;
    end

    prio_pick #(.NUM_WIN(NUM_WIN)) pick_i (
        .m_i   (mt),
        .hit_o (sel_hit),
        .idx_o (sel_idx),
        .addr_o(sel_addr),
        .cb_o  (sel_cb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_valid   <= 1'b0;
            xl_hit     <= 1'b0;
            xl_decerr  <= 1'b0;
            xl_win     <= '0;
            xl_addr    <= '0;
            xl_cardbus <= 1'b0;
        end else begin
            xl_valid   <= lk_valid;
            xl_hit     <= lk_valid && sel_hit;
            xl_decerr  <= lk_valid && !sel_hit;
            xl_win     <= (lk_valid && sel_hit) ? sel_idx : '0;
            xl_addr    <= (lk_valid && sel_hit) ? sel_addr : '0;
            xl_cardbus <= lk_valid && sel_hit && sel_cb;
        end
    end

endmodule

// File: rtl/l2p_xlate_checker.sv
module l2p_xlate_checker
    import l2p_xlate_pkg::*;
#(
    parameter int NUM_WIN = 3,
    localparam int WIN_IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic [XA_W-1:0]    lk_addr,
    input logic               xl_valid,
    input logic               xl_hit,
    input logic               xl_decerr,
    input logic [WIN_IW-1:0]  xl_win,
    input logic [XA_W-1:0]    xl_addr,
    input logic               xl_cardbus,
    input logic [NUM_WIN-1:0] hit_vec,
    input logic [NUM_WIN-1:0] win_en
);

    logic [NUM_WIN-1:0] prev_hits;
    logic [NUM_WIN-1:0] below_mask;

    always_ff @(posedge clk) prev_hits <= hit_vec;

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_WIN; i++)
            if (i < int'(xl_win)) below_mask[i] = 1'b1;
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> xl_valid);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !xl_valid);
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !xl_valid |-> (!xl_hit && !xl_decerr && !xl_cardbus && xl_addr == '0));
    a_r4_hit_xor_err: assert property (@(posedge clk) disable iff (rst)
        xl_valid |-> (xl_hit != xl_decerr));
    a_r9_miss_clean: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && !xl_hit) |-> (xl_addr == '0 && !xl_cardbus && xl_win == '0));
    a_r3_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && xl_hit) |-> xl_addr[GRAN_LSB-1:0] == $past(lk_addr[GRAN_LSB-1:0]));
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (xl_valid && xl_hit) |-> (prev_hits[xl_win] && (prev_hits & below_mask) == '0));

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
        a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
            !win_en[g] |-> !hit_vec[g]);
    end

endmodule

bind l2p_window_xlate l2p_xlate_checker #(.NUM_WIN(NUM_WIN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .xl_valid  (xl_valid),
    .xl_hit    (xl_hit),
    .xl_decerr (xl_decerr),
    .xl_win    (xl_win),
    .xl_addr   (xl_addr),
    .xl_cardbus(xl_cardbus),
    .hit_vec   (hit_vec),
    .win_en    (win_en)
);

// File: tb/l2p_window_xlate_tb.sv
module l2p_window_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        xl_valid, xl_hit, xl_decerr, xl_cardbus;
    logic [1:0]  xl_win;
    logic [31:0] xl_addr;

    always #2 clk = ~clk;  // 250 MHz

    l2p_window_xlate dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_decerr(xl_decerr),
        .xl_win(xl_win), .xl_addr(xl_addr), .xl_cardbus(xl_cardbus)
    );

    // Behavioural reference: plain arrays of window settings.
    logic [31:0] m_rng [3];
    logic [31:0] m_bas [3];
    logic [31:0] m_rmp [3];
    logic        e_valid, e_hit, e_err, e_cb;
    logic [1:0]  e_win;
    logic [31:0] e_addr;
    bit          started = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    string       cur_req = "R1";

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (rst) begin
            for (int w = 0; w < 3; w++) begin
                m_rng[w] = 0; m_bas[w] = 0; m_rmp[w] = 0;
            end
            {e_valid, e_hit, e_err, e_cb, e_win, e_addr} = '0;
        end else begin
            // R10: result of this edge's lookup, using settings before any write (R11)
            {e_valid, e_hit, e_err, e_cb, e_win, e_addr} = '0;
            e_valid = lk_valid;
            if (lk_valid) begin
                e_err = 1;
                for (int w = 0; w < 3; w++) begin
                    if (!e_hit && m_rmp[w][0] && (((lk_addr ^ m_bas[w]) & m_rng[w]) == 0)) begin
                        e_hit  = 1;
                        e_err  = 0;
                        e_win  = w[1:0];
                        e_cb   = m_rmp[w][2];
                        e_addr = ((m_rmp[w] & 32'hFFFF_8000) & m_rng[w]) | (lk_addr & ~m_rng[w]);
                    end
                end
            end
            // R2 map: window w at 0x120 + 12*w, fields range/base/remap
            if (cfg_we) begin
                for (int w = 0; w < 3; w++) begin
                    if (cfg_addr == 12'h120 + 12 * w) m_rng[w] = cfg_wdata & 32'hFFFF_8000;
                    if (cfg_addr == 12'h124 + 12 * w) m_bas[w] = cfg_wdata & 32'hFFFF_8000;
                    if (cfg_addr == 12'h128 + 12 * w) m_rmp[w] = cfg_wdata & 32'hFFFF_8005;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_checks++;
            if ({xl_valid, xl_hit, xl_decerr, xl_cardbus, xl_win, xl_addr} !==
                {e_valid, e_hit, e_err, e_cb, e_win, e_addr}) begin
                n_fail++;
                $display("FAIL %s: got v=%0b hit=%0b err=%0b cb=%0b win=%0d addr=%08h, exp v=%0b hit=%0b err=%0b cb=%0b win=%0d addr=%08h",
                         cur_req, xl_valid, xl_hit, xl_decerr, xl_cardbus, xl_win, xl_addr,
                         e_valid, e_hit, e_err, e_cb, e_win, e_addr);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: got running, exp finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; lk_valid = 0;
    endtask

    task automatic look(input logic [31:0] a);
        @(negedge clk);
        cfg_we = 0; lk_valid = 1; lk_addr = a;
    endtask

    task automatic wr_look(input logic [11:0] wa, input logic [31:0] d, input logic [31:0] a);
        @(negedge clk);
        cfg_we = 1; cfg_addr = wa; cfg_wdata = d; lk_valid = 1; lk_addr = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 0; lk_valid = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: empty map, every lookup misses
        cur_req = "R1/R9";
        look(32'h0000_0000); look(32'h1000_0000); look(32'hFFFF_FFFF);
        idle(2);

        // R2 and R3: program windows; low bits of base are dropped
        cur_req = "R2/R3";
        wr(12'h120, 32'hFFF0_0000);        // win0: 1 MB
        wr(12'h124, 32'h1000_7FFF);
        wr(12'h128, 32'h8000_0001);
        wr(12'h12C, 32'hFFFF_0000);        // win1: 64 KB, CardBus
        wr(12'h130, 32'h2000_0000);
        wr(12'h134, 32'h4001_0005);
        wr(12'h138, 32'hFFFF_8ABC);        // io: 32 KB, low range bits dropped
        wr(12'h13C, 32'h3000_0000);
        wr(12'h140, 32'h0000_8001);
        wr(12'h14C, 32'hFFFF_FFFF);        // R2: unmapped offsets ignored
        wr(12'h11C, 32'h0000_0001);
        wr(12'h126, 32'h0000_0000);
        idle(1);

        // R4 and R6: hits and boundaries
        cur_req = "R4/R6";
        look(32'h1000_0000); look(32'h100F_FFFF); look(32'h1010_0000); look(32'h0FFF_FFFF);
        look(32'h1003_4567);
        // R7: CardBus flag from window 1
        cur_req = "R7";
        look(32'h2000_1234); look(32'h2000_FFFF); look(32'h2001_0000);
        // R3: I/O window with low offset bits passed through
        cur_req = "R3/R7";
        look(32'h3000_7FFF); look(32'h3000_0001); look(32'h3000_8000);
        idle(1);

        // R7: I/O window switched to CardBus
        cur_req = "R7";
        wr(12'h140, 32'h0000_8005);
        look(32'h3000_0100);
        idle(1);

        // R5: clear enable of window 1
        cur_req = "R5";
        wr(12'h134, 32'h4001_0004);
        look(32'h2000_0010); look(32'h2000_FFF0);
        idle(1);

        // R8: overlap window 2 and window 1 onto window 0
        cur_req = "R8";
        wr(12'h13C, 32'h1000_0000);
        wr(12'h134, 32'h4001_0001);
        wr(12'h130, 32'h1000_0000);
        look(32'h1000_0044); look(32'h1000_8000);
        wr(12'h128, 32'h8000_0000);        // disable win0: win1 then wins
        look(32'h1000_0044); look(32'h1000_8000);
        idle(1);

        // R11: a write and a lookup in the same cycle
        cur_req = "R11";
        wr_look(12'h128, 32'h9000_0001, 32'h1000_0010);
        look(32'h1000_0010);
        wr_look(12'h128, 32'h0000_0000, 32'h1000_0020);
        look(32'h1000_0020);
        idle(1);

        // R10: mixed random traffic, valid gaps
        cur_req = "R10/R6";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {$urandom_range(0, 3) == 0 ? 4'h3 : 4'h1, 4'h0, 24'($urandom)};
            if ($urandom_range(0, 3) == 0) idle(1);
            else look(a);
        end
        idle(3);

        // R1: reset returns to an empty map
        cur_req = "R1";
        rst = 1;
        idle(2);
        rst = 0;
        look(32'h1000_0000); look(32'h3000_0000);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule